// File: doc/BRIEF.md
# Interrupt Message Capture Queue

This block sits behind the inbound path of a host bridge and captures message-signalled interrupt writes. Every write presented on the message port is compared against a programmable address window. A write that falls inside the window while capture is enabled is queued together with its full 64-bit address and its 32-bit data word. Software drains the queue through a small register interface. It learns that entries are waiting from a status bit and from a level interrupt.

Each queued entry is released only after software has read all three of its words: the data word, the low address word and the high address word. The three reads may come in any order, and repeating a read of the same word is harmless. A write that arrives while the queue is full is discarded, and a sticky overflow flag records the loss. With the usual setup there are sixteen vectors, vector n writes the value n to window base + 4·n, and the window size is 4096 bytes.

Top module: `msi_capture`

## Requirements
- R1: The register map is: window base low at 0x04, window base high at 0x08, window size at 0x0C, capture enable (bit 0) at 0x14, status at 0x18, head data at 0x20, head address low at 0x24, head address high at 0x28. Base, size and enable read back what was written, and read data is valid combinationally in the cycle the read is presented.
- R2: A message write is queued only when enable bit 0 is 1 and base ≤ address < base + size (64-bit compare). Any other write leaves the queue and the status unchanged.
- R3: Entries leave in arrival order. The head data and address words read back exactly the captured values.
- R4: Status bit 0 is 1 exactly while the queue holds at least one entry. The state becomes visible one cycle after the capturing write.
- R5: The head entry is removed at the clock edge of the last of its three word reads (0x20, 0x24, 0x28), in any order. Until then, repeated reads of the same word do not remove it. The read tracking restarts for the next entry.
- R6: The queue holds 16 entries. A write accepted by the window while the queue is full is dropped and sets status bit 1, which stays set until reset.
- R7: The output irq equals status bit 0 AND enable bit 0.
- R8: Reads of 0x20, 0x24 or 0x28 while the queue is empty return zero and do not count toward a later entry's removal.
- R9: After reset all registers read zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data, combinational |
| msgValid | input | 1 | Inbound interrupt message write valid |
| msgAddr | input | 64 | Inbound message address |
| msgData | input | 32 | Inbound message data |
| irq | output | 1 | Level interrupt while entries are pending and capture is enabled |

## Verification
A captured write changes status and irq at the clock edge that samples msgValid, so the bench reads status at the next falling edge. A pop takes effect on the edge of the completing read, so the following read already sees the next head. Register read data is combinational, and the bench samples it one time unit after it drives a read at a falling edge. Expected head values are computed as base + 4·n and n for vector n, and the read order is rotated across the sixteen entries.

// File: rtl/msi_capture_pkg.sv
package msi_capture_pkg;
  localparam logic [7:0] OFS_BASE_LO = 8'h04;
  localparam logic [7:0] OFS_BASE_HI = 8'h08;
  localparam logic [7:0] OFS_SIZE    = 8'h0C;
  localparam logic [7:0] OFS_ENABLE  = 8'h14;
  localparam logic [7:0] OFS_STATUS  = 8'h18;
  localparam logic [7:0] OFS_DATA    = 8'h20;
  localparam logic [7:0] OFS_ADDR_LO = 8'h24;
  localparam logic [7:0] OFS_ADDR_HI = 8'h28;

  typedef struct packed {
    logic push;
    logic pop;
  } queueCmd_t;
endpackage

// File: rtl/msi_queue.sv
module msi_queue
  import msi_capture_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  queueCmd_t         cmd,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic              empty,
  output logic              full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = ADDR_W + DATA_W;

  logic [ENT_W-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign {headAddr, headData} = empty ? '0 : store[rdPtr];

  always_ff @(posedge clk) begin
    if (cmd.push) store[wrPtr] <= {inAddr, inData};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (cmd.push) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (cmd.pop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CNT_W'(cmd.push) - CNT_W'(cmd.pop);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    cmd.push |-> !full);
  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.pop |-> !empty);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == CNT_W'($past(count) + CNT_W'($past(cmd.push)) - CNT_W'($past(cmd.pop))));
endmodule

// File: rtl/msi_ctrl.sv
module msi_ctrl
  import msi_capture_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [7:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              msgValid,
  input  logic [ADDR_W-1:0] msgAddr,
  input  logic [ADDR_W-1:0] headAddr,
  input  logic [DATA_W-1:0] headData,
  input  logic              empty,
  input  logic              full,
  output queueCmd_t         cmd,
  output logic              irq
);
  logic [31:0]       baseLo, baseHi, winSize;
  logic              enable, overflow;
  logic [2:0]        seen, seenNext;
  logic [ADDR_W-1:0] base, offset;
  logic              inWindow, hit, wordRead;

  assign base     = {baseHi, baseLo};
  assign offset   = msgAddr - base;
  assign inWindow = (msgAddr >= base) && (offset < ADDR_W'(winSize));
  assign hit      = msgValid && enable && inWindow;

  always_comb begin
    seenNext = seen;
    wordRead = 1'b0;
    if (regRdEn && !empty) begin
      unique case (regAddr)
        OFS_DATA:    begin seenNext[0] = 1'b1; wordRead = 1'b1; end
        OFS_ADDR_LO: begin seenNext[1] = 1'b1; wordRead = 1'b1; end
        OFS_ADDR_HI: begin seenNext[2] = 1'b1; wordRead = 1'b1; end
        default: ;
      endcase
    end
  end

  assign cmd.push = hit && !full;
  assign cmd.pop  = wordRead && (seenNext == 3'b111);
  assign irq      = !empty && enable;

  always_ff @(posedge clk) begin
    if (rst) begin
      baseLo   <= '0;
      baseHi   <= '0;
      winSize  <= '0;
      enable   <= 1'b0;
      overflow <= 1'b0;
      seen     <= '0;
    end else begin
      if (regWrEn) begin
        unique case (regAddr)
          OFS_BASE_LO: baseLo  <= regWdata;
          OFS_BASE_HI: baseHi  <= regWdata;
          OFS_SIZE:    winSize <= regWdata;
          OFS_ENABLE:  enable  <= regWdata[0];
          default: ;
        endcase
      end
      if (hit && full) overflow <= 1'b1;
      if (cmd.pop) seen <= '0;
      else if (wordRead) seen <= seenNext;
    end
  end

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      OFS_BASE_LO: regRdata = baseLo;
      OFS_BASE_HI: regRdata = baseHi;
      OFS_SIZE:    regRdata = winSize;
      OFS_ENABLE:  regRdata = {31'b0, enable};
      OFS_STATUS:  regRdata = {30'b0, overflow, !empty};
      OFS_DATA:    regRdata = 32'(headData);
      OFS_ADDR_LO: regRdata = headAddr[31:0];
      OFS_ADDR_HI: regRdata = headAddr[ADDR_W-1:32];
      default: ;
    endcase
  end

  assert_pop_needs_read_R5: assert property (@(posedge clk) disable iff (rst)
    cmd.pop |-> regRdEn);
  assert_irq_rise_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> ($past(cmd.push) || $past(regWrEn)));
  assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    $past(overflow) |-> overflow);
  assert_capture_gated_R2: assert property (@(posedge clk) disable iff (rst)
    cmd.push |-> (enable && msgValid));
endmodule

// File: rtl/msi_capture.sv
module msi_capture
  import msi_capture_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        msgValid,
  input  logic [63:0] msgAddr,
  input  logic [31:0] msgData,
  output logic        irq
);
  queueCmd_t   cmd;
  logic [63:0] headAddr;
  logic [31:0] headData;
  logic        empty, full;

  msi_ctrl #(.DATA_W(32), .ADDR_W(64)) u_ctrl (
    .clk, .rst, .regWrEn, .regRdEn, .regAddr, .regWdata, .regRdata,
    .msgValid, .msgAddr, .headAddr, .headData, .empty, .full, .cmd, .irq
  );

  msi_queue #(.DEPTH(DEPTH), .DATA_W(32), .ADDR_W(64)) u_queue (
    .clk, .rst, .cmd, .inAddr(msgAddr), .inData(msgData),
    .headAddr, .headData, .empty, .full
  );
endmodule

// File: tb/msi_capture_bench.sv
module msi_capture_bench;
  logic        clk = 0, rst = 1;
  logic        regWrEn = 0, regRdEn = 0;
  logic [7:0]  regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic        msgValid = 0;
  logic [63:0] msgAddr = 0;
  logic [31:0] msgData = 0;
  logic        irq;
  int errors = 0, checks = 0;
  bit done = 0;

  localparam logic [63:0] BASE = 64'h0000_0001_2345_6000;

  always #5 clk = ~clk;

  msi_capture u_msi_capture (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic rdReg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic sendMsg(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    msgValid = 1; msgAddr = a; msgData = d;
    @(negedge clk);
    msgValid = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R9 reset state
    rdReg(8'h18, v); chk("R9 status", v, 0);
    rdReg(8'h04, v); chk("R9 base lo", v, 0);
    chk("R9 irq", 32'(irq), 0);
    // R1 programming and readback
    wrReg(8'h04, BASE[31:0]);
    wrReg(8'h08, BASE[63:32]);
    wrReg(8'h0C, 32'd4096);
    rdReg(8'h04, v); chk("R1 base lo", v, BASE[31:0]);
    rdReg(8'h08, v); chk("R1 base hi", v, BASE[63:32]);
    rdReg(8'h0C, v); chk("R1 size", v, 4096);
    // R2 disabled capture ignored
    sendMsg(BASE, 32'h7);
    rdReg(8'h18, v); chk("R2 disabled", v, 0);
    wrReg(8'h14, 32'h1);
    rdReg(8'h14, v); chk("R1 enable", v, 1);
    // R2 outside window
    sendMsg(BASE - 4, 32'h7);
    sendMsg(BASE + 4096, 32'h7);
    rdReg(8'h18, v); chk("R2 outside window", v, 0);
    chk("R7 irq idle", 32'(irq), 0);
    // fill 16 vectors
    for (int n = 0; n < 16; n++) begin
      sendMsg(BASE + 64'(4 * n), 32'(n));
      if (n == 0) begin
        rdReg(8'h18, v); chk("R4 pending", v, 1);
        chk("R7 irq set", 32'(irq), 1);
      end
    end
    // R6 overflow
    sendMsg(BASE + 64'd8, 32'hAA);
    rdReg(8'h18, v); chk("R6 overflow", v, 3);
    // R7 irq follows enable
    wrReg(8'h14, 32'h0);
    chk("R7 irq masked", 32'(irq), 0);
    wrReg(8'h14, 32'h1);
    chk("R7 irq unmasked", 32'(irq), 1);
    // R5 repeated read does not pop
    rdReg(8'h20, v);
    rdReg(8'h20, v); chk("R5 repeat data", v, 0);
    rdReg(8'h24, v); chk("R5 still head", v, BASE[31:0]);
    rdReg(8'h18, v); chk("R5 still pending", v, 3);
    rdReg(8'h28, v); chk("R3 hi word", v, BASE[63:32]);
    // drain rest with rotated orders (R3, R5)
    for (int n = 1; n < 16; n++) begin
      logic [31:0] d, lo, hi;
      case (n % 3)
        0: begin rdReg(8'h20, d); rdReg(8'h24, lo); rdReg(8'h28, hi); end
        1: begin rdReg(8'h28, hi); rdReg(8'h20, d); rdReg(8'h24, lo); end
        default: begin rdReg(8'h24, lo); rdReg(8'h28, hi); rdReg(8'h20, d); end
      endcase
      chk($sformatf("R3 data n=%0d", n), d, 32'(n));
      chk($sformatf("R3 addr lo n=%0d", n), lo, BASE[31:0] + 32'(4 * n));
      chk($sformatf("R5 addr hi n=%0d", n), hi, BASE[63:32]);
    end
    rdReg(8'h18, v); chk("R4 drained", v, 2);
    chk("R7 irq drained", 32'(irq), 0);
    // R8 empty reads
    rdReg(8'h20, v); chk("R8 empty data", v, 0);
    rdReg(8'h24, v); chk("R8 empty lo", v, 0);
    rdReg(8'h28, v);
    sendMsg(BASE + 64'd4092, 32'h55);
    rdReg(8'h20, v); chk("R2 top edge data", v, 32'h55);
    rdReg(8'h24, v); chk("R2 top edge addr", v, BASE[31:0] + 32'd4092);
    rdReg(8'h18, v); chk("R8 no stale flags", v, 3);
    rdReg(8'h28, v);
    rdReg(8'h18, v); chk("R5 pop on third", v, 2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule